// File: doc/BRIEF.md
# Paged Dual-Read Data Memory Addresser

This block is the operand store of a small signal processor. It gathers three kinds of storage behind one two-dimensional address space: a 200-word by 16-bit data RAM, a 128-word coefficient ROM whose contents are computed, and four general registers. Every cycle it serves two reads, one for the X bus and one for the Y bus, and at most one write. The X bus feeds the multiplier and the Y bus feeds the ALU. Each access names a 2-bit page, and the page decides both the storage and the pointer that supplies the word index.

There are three pointer registers. Pointer A and pointer B index the RAM. Pointer C indexes the ROM. The general-register page uses the low two bits of pointer A. Each pointer can be loaded with a value or stepped by one. A step takes effect after the accesses of that cycle, so it acts as a post-increment. A write aimed at the ROM page stores nothing and raises a fault flag.

A two-state fault machine drives the fault flag. Its states are FLT_IDLE and FLT_HIT. On a rejected write it moves from FLT_IDLE to FLT_HIT, or stays in FLT_HIT. In any other cycle it moves from FLT_HIT to FLT_IDLE, or stays in FLT_IDLE. The flag is high only while the machine is in FLT_HIT.

Top module: `dmem_pager`

## Requirements
- R1: While `rst_n` is low, `x_data`, `y_data` and `wr_fault` are 0, all three pointers are 0 and all four general registers are 0.
- R2: The page encoding is 0 for RAM through pointer A, 1 for RAM through pointer B, 2 for ROM through pointer C, and 3 for general register number `ptr_a[1:0]`. `x_page` and `y_page` select their sources independently. The word read in a cycle appears on `x_data` or `y_data` after the next rising clock edge.
- R3: A write with `wr_page` 0 or 1 stores `wr_data` into the RAM word at pointer A or pointer B, and later reads of that word return it.
- R4: When `ptr_load[i]` is high, pointer i takes `ptr_value` at the next edge. Bit 0 selects A, bit 1 selects B and bit 2 selects C. A value at or beyond the pointer's range (200 for A and B, 128 for C) loads 0 instead. A load takes priority over a step in the same cycle.
- R5: When `ptr_step[i]` is high (same bit order as R4), pointer i advances by one after the accesses of that cycle, which still use the old value. A RAM pointer wraps from 199 to 0 and the ROM pointer wraps from 127 to 0. A pointer that is neither loaded nor stepped keeps its value.
- R6: ROM word i is the 8-bit value of i in bits 15:8 and its bitwise inverse in bits 7:0. For example, word 5 reads 16'h05FA.
- R7: A read and a write to the same RAM word or general register in the same cycle return the old contents. The new contents are seen from the next cycle on.
- R8: A write with `wr_page` 2 changes no storage. It raises `wr_fault` for exactly the cycle after it, so each rejected write gives one high cycle.
- R9: `wr_fault` is low in every cycle that does not follow a rejected write.
- R10: A write with `wr_page` 3 stores `wr_data` into general register `ptr_a[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| x_page | input | 2 | Page of the X-bus read |
| y_page | input | 2 | Page of the Y-bus read |
| wr_en | input | 1 | Write request |
| wr_page | input | 2 | Page of the write |
| wr_data | input | 16 | Write data |
| ptr_load | input | 3 | Load request per pointer (bit 0 A, bit 1 B, bit 2 C) |
| ptr_step | input | 3 | Post-increment request per pointer, same bit order |
| ptr_value | input | 8 | Value for pointer loads |
| x_data | output | 16 | Registered X-bus read data |
| y_data | output | 16 | Registered Y-bus read data |
| wr_fault | output | 1 | One-cycle flag after a rejected ROM-page write |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a read and a write to the same storage. The bench aims X at a RAM word, and later at a general register, while it writes that same location, and expects the old word first and the new word one cycle later. The second pair is a rejected ROM-page write and a ROM read. The bench issues both in one cycle and then expects the fault flag together with unchanged ROM, RAM and register contents. A back-to-back pair of rejected writes checks that the fault machine stays in FLT_HIT.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    // Page codes: the write decode and both read selectors depend on these values
    typedef enum logic [1:0] {
        PG_RAM_A = 2'd0,
        PG_RAM_B = 2'd1,
        PG_COEF  = 2'd2,
        PG_GREG  = 2'd3
    } page_e;

    typedef enum logic {
        FLT_IDLE = 1'b0,
        FLT_HIT  = 1'b1
    } fault_state_e;

endpackage

// File: rtl/dmem_ptr.sv
// One pointer register: load has priority, step wraps at LIMIT-1
module dmem_ptr #(
    parameter int LIMIT = 200,
    parameter int PW    = 8,
    parameter int VW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [VW-1:0] value,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST     = PW'(LIMIT - 1);
    localparam logic [VW:0]   LIMIT_VW = (VW + 1)'(LIMIT);

    logic [PW-1:0] ptr_next;
    logic          value_ok;

    assign value_ok = ({1'b0, value} < LIMIT_VW);

    always_comb begin
        ptr_next = ptr;
        if (load) begin
            ptr_next = value_ok ? PW'(value) : '0;
        end else if (step) begin
            ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_next;
    end
endmodule

// File: rtl/dmem_ram.sv
// Data RAM: NRD asynchronous read ports, one synchronous write port
module dmem_ram #(
    parameter int DEPTH = 200,
    parameter int W     = 16,
    parameter int AW    = 8,
    parameter int NRD   = 2
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr <= TOP)) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] <= TOP) ? mem[raddr[p]] : '0;
    end
endmodule

// File: rtl/dmem_coef_rom.sv
// Coefficient ROM: entry g = {g, ~g} on two half-words, built by generate
module dmem_coef_rom #(
    parameter int DEPTH = 128,
    parameter int W     = 16,
    parameter int AW    = 7
) (
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  word
);
    localparam int HALF = W / 2;

    logic [W-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        localparam logic [HALF-1:0] IDX = HALF'(g);
        assign tbl[g] = {IDX, ~IDX};
    end

    assign word = tbl[addr];
endmodule

// File: rtl/dmem_port_sel.sv
// Source selector for one read bus
module dmem_port_sel #(
    parameter int W = 16
) (
    input  dmem_pkg::page_e page,
    input  logic [W-1:0]    ram_a_word,
    input  logic [W-1:0]    ram_b_word,
    input  logic [W-1:0]    coef_word,
    input  logic [W-1:0]    greg_word,
    output logic [W-1:0]    word
);
    import dmem_pkg::*;

    always_comb begin
        unique case (page)
            PG_RAM_A: word = ram_a_word;
            PG_RAM_B: word = ram_b_word;
            PG_COEF:  word = coef_word;
            PG_GREG:  word = greg_word;
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/dmem_fault_fsm.sv
// Fault flag machine: FLT_HIT for the cycle after every rejected write
module dmem_fault_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic reject,
    output logic fault
);
    import dmem_pkg::*;

    fault_state_e state, state_next;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FLT_IDLE;
        else        state <= state_next;
    end

    // transitions
    always_comb begin
        state_next = state;
        unique case (state)
            FLT_IDLE: state_next = reject ? FLT_HIT : FLT_IDLE;
            FLT_HIT:  state_next = reject ? FLT_HIT : FLT_IDLE;
            default:  state_next = FLT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            FLT_IDLE: fault = 1'b0;
            FLT_HIT:  fault = 1'b1;
            default:  fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmem_pager.sv
module dmem_pager #(
    parameter int RAM_DEPTH  = 200,
    parameter int COEF_DEPTH = 128,
    parameter int WORD_W     = 16,
    parameter int NGREG      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  x_page,
    input  logic [1:0]  y_page,
    input  logic        wr_en,
    input  logic [1:0]  wr_page,
    input  logic [15:0] wr_data,
    input  logic [2:0]  ptr_load,
    input  logic [2:0]  ptr_step,
    input  logic [7:0]  ptr_value,
    output logic [15:0] x_data,
    output logic [15:0] y_data,
    output logic        wr_fault
);
    import dmem_pkg::*;

    localparam int RAM_AW  = $clog2(RAM_DEPTH);
    localparam int COEF_AW = $clog2(COEF_DEPTH);
    localparam int GREG_AW = $clog2(NGREG);
    localparam int VAL_W   = RAM_AW;
    localparam int NRAMPTR = 2;
    localparam int NBUS    = 2;

    // ---------------- pointers ----------------
    logic [NRAMPTR-1:0][RAM_AW-1:0] ram_ptr;
    logic [RAM_AW-1:0]  ptr_a;
    logic [RAM_AW-1:0]  ptr_b;
    logic [COEF_AW-1:0] ptr_c;

    for (genvar i = 0; i < NRAMPTR; i++) begin : g_ram_ptr
        dmem_ptr #(.LIMIT(RAM_DEPTH), .PW(RAM_AW), .VW(VAL_W)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ptr_load[i]),
            .step  (ptr_step[i]),
            .value (ptr_value),
            .ptr   (ram_ptr[i])
        );
    end

    dmem_ptr #(.LIMIT(COEF_DEPTH), .PW(COEF_AW), .VW(VAL_W)) u_ptr_c (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ptr_load[2]),
        .step  (ptr_step[2]),
        .value (ptr_value),
        .ptr   (ptr_c)
    );

    assign ptr_a = ram_ptr[0];
    assign ptr_b = ram_ptr[1];

    // ---------------- write decode ----------------
    page_e             wr_pg;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_waddr;
    logic              greg_we;
    logic              wr_reject;

    assign wr_pg = page_e'(wr_page);

    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = ptr_a;
        greg_we   = 1'b0;
        wr_reject = 1'b0;
        if (wr_en) begin
            unique case (wr_pg)
                PG_RAM_A: ram_we = 1'b1;
                PG_RAM_B: begin
                    ram_we    = 1'b1;
                    ram_waddr = ptr_b;
                end
                PG_COEF:  wr_reject = 1'b1;
                PG_GREG:  greg_we = 1'b1;
                default:  wr_reject = 1'b0;
            endcase
        end
    end

    // ---------------- storage ----------------
    logic [NRAMPTR-1:0][WORD_W-1:0] ram_rd;
    logic [WORD_W-1:0]              coef_rd;

    dmem_ram #(.DEPTH(RAM_DEPTH), .W(WORD_W), .AW(RAM_AW), .NRD(NRAMPTR)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (wr_data),
        .raddr (ram_ptr),
        .rdata (ram_rd)
    );

    dmem_coef_rom #(.DEPTH(COEF_DEPTH), .W(WORD_W), .AW(COEF_AW)) u_rom (
        .addr (ptr_c),
        .word (coef_rd)
    );

    logic [WORD_W-1:0]  greg [NGREG];
    logic [GREG_AW-1:0] greg_idx;

    assign greg_idx = ptr_a[GREG_AW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NGREG; k++) greg[k] <= '0;
        end else if (greg_we) begin
            greg[greg_idx] <= wr_data;
        end
    end

    // ---------------- read buses ----------------
    logic [NBUS-1:0][1:0]        rd_page;
    logic [NBUS-1:0][WORD_W-1:0] rd_word;
    logic [NBUS-1:0][WORD_W-1:0] rd_q;

    assign rd_page = {y_page, x_page};

    for (genvar p = 0; p < NBUS; p++) begin : g_bus
        dmem_port_sel #(.W(WORD_W)) u_sel (
            .page       (page_e'(rd_page[p])),
            .ram_a_word (ram_rd[0]),
            .ram_b_word (ram_rd[1]),
            .coef_word  (coef_rd),
            .greg_word  (greg[greg_idx]),
            .word       (rd_word[p])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) rd_q[p] <= '0;
            else        rd_q[p] <= rd_word[p];
        end
    end

    assign x_data = rd_q[0];
    assign y_data = rd_q[1];

    // ---------------- fault flag ----------------
    dmem_fault_fsm u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .reject (wr_reject),
        .fault  (wr_fault)
    );
endmodule

// File: rtl/dmem_pager_chk.sv
module dmem_pager_chk #(
    parameter int RAM_DEPTH = 200,
    parameter int PW        = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_page,
    input logic          wr_fault,
    input logic [2:0]    ptr_load,
    input logic [2:0]    ptr_step,
    input logic [PW-1:0] ptr_value,
    input logic [PW-1:0] ptr_a,
    input logic [PW-1:0] ptr_b
);
    localparam logic [PW-1:0] LAST  = PW'(RAM_DEPTH - 1);
    localparam logic [PW:0]   LIMIT = (PW + 1)'(RAM_DEPTH);

    assert_fault_after_rom_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_page == 2'd2) |=> wr_fault);

    assert_fault_only_after_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fault |-> $past(wr_en && wr_page == 2'd2));

    assert_ram_ptr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_a <= LAST) && (ptr_b <= LAST));

    assert_load_takes_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load[0] && ({1'b0, ptr_value} < LIMIT)) |=> (ptr_a == $past(ptr_value)));

    assert_ram_ptr_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_step[0] && !ptr_load[0] && ptr_a == LAST) |=> (ptr_a == '0));

    assert_idle_ptr_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_load[1] && !ptr_step[1]) |=> $stable(ptr_b));
endmodule

bind dmem_pager dmem_pager_chk #(.RAM_DEPTH(RAM_DEPTH), .PW(RAM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_page   (wr_page),
    .wr_fault  (wr_fault),
    .ptr_load  (ptr_load),
    .ptr_step  (ptr_step),
    .ptr_value (ptr_value),
    .ptr_a     (ptr_a),
    .ptr_b     (ptr_b)
);

// File: tb/dmem_pager_test.sv
module dmem_pager_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  x_page, y_page, wr_page;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [2:0]  ptr_load, ptr_step;
    logic [7:0]  ptr_value;
    logic [15:0] x_data, y_data;
    logic        wr_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    dmem_pager uut (
        .clk(clk), .rst_n(rst_n), .x_page(x_page), .y_page(y_page),
        .wr_en(wr_en), .wr_page(wr_page), .wr_data(wr_data),
        .ptr_load(ptr_load), .ptr_step(ptr_step), .ptr_value(ptr_value),
        .x_data(x_data), .y_data(y_data), .wr_fault(wr_fault)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; ptr_load = 0; ptr_step = 0;
    endtask

    task automatic load_ptr(input int idx, input logic [7:0] v);
        ptr_load = 3'(1 << idx); ptr_value = v;
        tick();
        idle();
    endtask

    task automatic write(input logic [1:0] pg, input logic [15:0] d, input logic [2:0] stp);
        wr_en = 1; wr_page = pg; wr_data = d; ptr_step = stp;
        tick();
        idle();
    endtask

    task automatic read(input logic [1:0] xp, input logic [1:0] yp, input logic [2:0] stp);
        x_page = xp; y_page = yp; ptr_step = stp;
        tick();
        idle();
    endtask

    task automatic t_reset();
        check("R1 x_data", x_data, 16'h0);
        check("R1 y_data", y_data, 16'h0);
        check("R1 wr_fault", 16'(wr_fault), 16'h0);
    endtask

    task automatic t_pages();
        load_ptr(0, 8'd10);
        load_ptr(1, 8'd20);
        write(2'd0, 16'h1111, 3'b000);
        write(2'd1, 16'h2222, 3'b000);
        read(2'd0, 2'd1, 3'b000);
        check("R3 X via ptr A", x_data, 16'h1111);
        check("R3 Y via ptr B", y_data, 16'h2222);
        read(2'd1, 2'd0, 3'b000);
        check("R2 X via ptr B", x_data, 16'h2222);
        check("R2 Y via ptr A", y_data, 16'h1111);
    endtask

    task automatic t_step();
        load_ptr(0, 8'd40);
        for (int i = 0; i < 3; i++) write(2'd0, 16'hA000 + 16'(i), 3'b001);
        load_ptr(0, 8'd40);
        for (int i = 0; i < 3; i++) begin
            read(2'd0, 2'd0, 3'b001);
            check("R5 post-increment X", x_data, 16'hA000 + 16'(i));
            check("R5 post-increment Y", y_data, 16'hA000 + 16'(i));
        end
    endtask

    task automatic t_wrap();
        load_ptr(0, 8'd199);
        write(2'd0, 16'hBEEF, 3'b001);
        write(2'd0, 16'hCAFE, 3'b000);
        load_ptr(0, 8'd199);
        read(2'd0, 2'd0, 3'b001);
        check("R5 word 199", x_data, 16'hBEEF);
        read(2'd0, 2'd0, 3'b000);
        check("R5 RAM wrap to 0", x_data, 16'hCAFE);
    endtask

    task automatic t_load_rules();
        load_ptr(0, 8'd10);
        load_ptr(0, 8'd250);
        read(2'd0, 2'd0, 3'b000);
        check("R4 out-of-range A loads 0", x_data, 16'hCAFE);
        load_ptr(1, 8'd200);
        read(2'd0, 2'd1, 3'b000);
        check("R4 out-of-range B loads 0", y_data, 16'hCAFE);
        ptr_load = 3'b001; ptr_step = 3'b001; ptr_value = 8'd40;
        tick();
        idle();
        read(2'd0, 2'd0, 3'b000);
        check("R4 load beats step", x_data, 16'hA000);
    endtask

    task automatic t_rom();
        load_ptr(2, 8'd5);
        read(2'd2, 2'd2, 3'b000);
        check("R6 ROM word 5 on X", x_data, 16'h05FA);
        check("R6 ROM word 5 on Y", y_data, 16'h05FA);
        load_ptr(2, 8'hC3);
        read(2'd0, 2'd2, 3'b000);
        check("R4 ROM load out of range", y_data, 16'h00FF);
        load_ptr(2, 8'd127);
        read(2'd2, 2'd0, 3'b100);
        check("R6 ROM word 127", x_data, 16'h7F80);
        read(2'd2, 2'd0, 3'b000);
        check("R5 ROM wrap to 0", x_data, 16'h00FF);
    endtask

    task automatic t_greg();
        load_ptr(0, 8'd1);
        read(2'd3, 2'd3, 3'b000);
        check("R1 general register reset", x_data, 16'h0000);
        load_ptr(0, 8'd2);
        write(2'd3, 16'h1234, 3'b000);
        load_ptr(0, 8'd6);
        read(2'd3, 2'd0, 3'b000);
        check("R10 register via ptr_a[1:0]", x_data, 16'h1234);
        load_ptr(0, 8'd3);
        read(2'd3, 2'd0, 3'b000);
        check("R10 other register untouched", x_data, 16'h0000);
    endtask

    task automatic t_rdw();
        load_ptr(0, 8'd30);
        write(2'd0, 16'h0A0A, 3'b000);
        check("R9 no fault after RAM write", 16'(wr_fault), 16'h0);
        wr_en = 1; wr_page = 2'd0; wr_data = 16'h5555; x_page = 2'd0;
        tick();
        idle();
        check("R7 RAM same-cycle read is old", x_data, 16'h0A0A);
        read(2'd0, 2'd0, 3'b000);
        check("R7 RAM new data next cycle", x_data, 16'h5555);
        load_ptr(0, 8'd2);
        wr_en = 1; wr_page = 2'd3; wr_data = 16'h7777; x_page = 2'd3;
        tick();
        idle();
        check("R7 register same-cycle read is old", x_data, 16'h1234);
        read(2'd3, 2'd0, 3'b000);
        check("R7 register new data next cycle", x_data, 16'h7777);
    endtask

    task automatic t_fault();
        load_ptr(0, 8'd30);
        load_ptr(2, 8'd5);
        wr_en = 1; wr_page = 2'd2; wr_data = 16'hFFFF; x_page = 2'd2; y_page = 2'd0;
        tick();
        check("R8 fault after ROM write", 16'(wr_fault), 16'h1);
        check("R8 ROM read beside rejected write", x_data, 16'h05FA);
        tick();
        idle();
        check("R8 fault held for second rejected write", 16'(wr_fault), 16'h1);
        tick();
        check("R9 fault drops", 16'(wr_fault), 16'h0);
        check("R8 ROM unchanged", x_data, 16'h05FA);
        check("R8 RAM unchanged", y_data, 16'h5555);
        read(2'd3, 2'd2, 3'b000);
        check("R8 register unchanged", x_data, 16'h7777);
        check("R9 fault stays low", 16'(wr_fault), 16'h0);
    endtask

    initial begin
        rst_n = 0; x_page = 0; y_page = 0; wr_page = 0; wr_data = 0; ptr_value = 0;
        idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_pages();
        t_step();
        t_wrap();
        t_load_rules();
        t_rom();
        t_greg();
        t_rdw();
        t_fault();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule